// File: doc/BRIEF.md
# Per-Pin Edge Interrupt and Wakeup Unit

This block watches every pin of a general purpose port and turns selected transitions into interrupt events. Software arms each pin separately for rising transitions, falling transitions, or both. An armed transition is latched by a flop that the pin itself clocks, so it is caught even while the system clock is stopped. The captured event then crosses into the bus clock domain and sets a sticky pending bit. Rising and falling events have separate pending views.

Pending bits are cleared by writing ones to a clear register. One write clears the rising and falling bit of every selected pin. The block drives three outputs. The first is a port summary of all pending bits. The second is an interrupt output that ORs that summary with an outside interrupt line. The third is a wakeup output. It is built purely from combinational logic, so it can bring the chip out of power-down before any clock runs. Only transitions are detected; a steady level never raises an event.

The register port is a plain single-cycle access. A write takes effect on the clock edge where the write enable is high. Read data is combinational on the same address lines. Neither the register port nor the pins carry a stream, so neither has a ready/valid handshake.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every register reads zero, and `irq_o`, `port_pend_o` and `wake_o` are low.
- R2: A low-to-high transition on a pin whose rise-arm bit is set sets that pin's bit in the rise-pending register (address 2). A low-to-high transition on a pin that is not rise-armed leaves that register unchanged.
- R3: A high-to-low transition on a pin whose fall-arm bit is set sets that pin's bit in the fall-pending register (address 3). A pin armed for both directions records each transition in its own register.
- R4: Pending bits are sticky. Writing to the clear register (address 4) clears both pending bits of every pin whose data bit is 1. Data bits that are 0 change nothing. The clear register reads zero.
- R5: If a new event for a pin reaches the pending logic in the same cycle as a clear for that pin, the pending bit stays set.
- R6: No level mode exists. A pin held high after its pending bit is cleared raises no new event.
- R7: Clearing a pin's arm bit stops new events for that pin but keeps any bit already pending.
- R8: `wake_o` rises on an armed transition with the clock stopped. It stays high while any pending bit or any captured but not yet synchronized event remains.
- R9: `port_pend_o` is the OR of all pending bits and also reads as bit 0 of the summary register (address 5). `irq_o` is `port_pend_o` OR `ext_irq_i`.
- R10: Address map (3 bits): 0 is rise-arm (read/write), 1 is fall-arm (read/write), 2 is rise-pending, 3 is fall-pending, 5 is summary (these three read only). Arm registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; may be stopped in power-down |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Port pin levels |
| ext_irq_i | input | 1 | Outside interrupt line merged into `irq_o` |
| bus_we_i | input | 1 | Register write enable |
| bus_addr_i | input | 3 | Register address for reads and writes |
| bus_wdata_i | input | NPINS | Write data |
| bus_rdata_o | output | NPINS | Combinational read data |
| irq_o | output | 1 | Shared interrupt output |
| port_pend_o | output | 1 | OR of all pending bits |
| wake_o | output | 1 | Asynchronous wakeup request |

## Verification
The hardest cases to reach are the collision between a new event and a clear of the same pin, and capture with no clock. For the collision, the bench starts from an already pending pin. It makes a fresh transition just after a falling clock edge. It then places the clear write exactly on the third rising edge, the one where the synchronized event reaches the pending logic. To test capture with no clock, the bench holds the clock low. It moves an armed pin and checks `wake_o` and the still-empty pending summary. Only then does it restart the clock and watch the pending bit appear.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    SEL_RISE_ARM  = 3'd0,
    SEL_FALL_ARM  = 3'd1,
    SEL_RISE_PEND = 3'd2,
    SEL_FALL_PEND = 3'd3,
    SEL_CLEAR     = 3'd4,
    SEL_SUMMARY   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_edge_cap.sv
// One capture flop per pin and direction, clocked by the pin itself.
// It toggles on each armed transition, so it never needs a clear pulse
// from the bus clock domain.
module gpio_edge_cap #(
  parameter bit FALLING = 1'b0
) (
  input  logic pin_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic tog_o
);
  logic tog_q;

  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge pin_i or negedge rst_ni) begin
        if (!rst_ni)    tog_q <= 1'b0;
        else if (arm_i) tog_q <= ~tog_q;
      end
    end else begin : g_rise
      always_ff @(posedge pin_i or negedge rst_ni) begin
        if (!rst_ni)    tog_q <= 1'b0;
        else if (arm_i) tog_q <= ~tog_q;
      end
    end
  endgenerate

  assign tog_o = tog_q;
endmodule

// File: rtl/gpio_edge_sync.sv
// Two-flop synchronizer for a vector of toggle flags.
module gpio_edge_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_edge_pend.sv
// Turns synchronized toggles into events and keeps the sticky pending bits.
// It also forms the clock-free "unseen" term for the wakeup.
module gpio_edge_pend #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] rise_raw_i,
  input  logic [NPINS-1:0] fall_raw_i,
  input  logic [NPINS-1:0] rise_sync_i,
  input  logic [NPINS-1:0] fall_sync_i,
  input  logic             clr_we_i,
  input  logic [NPINS-1:0] clr_mask_i,
  output logic [NPINS-1:0] rise_pend_o,
  output logic [NPINS-1:0] fall_pend_o,
  output logic             unseen_o
);
  logic [NPINS-1:0] rise_seen_q, fall_seen_q;
  logic [NPINS-1:0] rise_evt, fall_evt, clr_bits;
  logic [NPINS-1:0] rise_pend_q, fall_pend_q;

  assign rise_evt = rise_sync_i ^ rise_seen_q;
  assign fall_evt = fall_sync_i ^ fall_seen_q;
  assign clr_bits = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_seen_q <= '0;
      fall_seen_q <= '0;
      rise_pend_q <= '0;
      fall_pend_q <= '0;
    end else begin
      rise_seen_q <= rise_sync_i;
      fall_seen_q <= fall_sync_i;
      // A new event outranks a clear in the same cycle.
      rise_pend_q <= (rise_pend_q & ~clr_bits) | rise_evt;
      fall_pend_q <= (fall_pend_q & ~clr_bits) | fall_evt;
    end
  end

  assign rise_pend_o = rise_pend_q;
  assign fall_pend_o = fall_pend_q;
  // Captured but not yet acknowledged. This needs no clock.
  assign unseen_o = |((rise_raw_i ^ rise_seen_q) | (fall_raw_i ^ fall_seen_q));

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_chk
      a_r5_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_evt[i] |=> rise_pend_q[i]);
      a_r5_edge_wins_f: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_evt[i] |=> fall_pend_q[i]);
      a_r4_clear_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && clr_mask_i[i] && !rise_evt[i]) |=> !rise_pend_q[i]);
      a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_pend_q[i] && !(clr_we_i && clr_mask_i[i])) |=> rise_pend_q[i]);
    end
  endgenerate
endmodule

// File: rtl/gpio_edge_regs.sv
// Arm registers, clear decode and read mux.
module gpio_edge_regs
  import gpio_edge_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  rise_pend_i,
  input  logic [NPINS-1:0]  fall_pend_i,
  input  logic              summary_i,
  output logic [NPINS-1:0]  rise_arm_o,
  output logic [NPINS-1:0]  fall_arm_o,
  output logic              clr_we_o,
  output logic [NPINS-1:0]  rdata_o
);
  logic [NPINS-1:0] rise_arm_q, fall_arm_q;
  reg_sel_e sel;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_arm_q <= '0;
      fall_arm_q <= '0;
    end else if (we_i) begin
      if (sel == SEL_RISE_ARM) rise_arm_q <= wdata_i;
      if (sel == SEL_FALL_ARM) fall_arm_q <= wdata_i;
    end
  end

  assign clr_we_o   = we_i && (sel == SEL_CLEAR);
  assign rise_arm_o = rise_arm_q;
  assign fall_arm_o = fall_arm_q;

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_RISE_ARM:  rdata_o = rise_arm_q;
      SEL_FALL_ARM:  rdata_o = fall_arm_q;
      SEL_RISE_PEND: rdata_o = rise_pend_i;
      SEL_FALL_PEND: rdata_o = fall_pend_i;
      SEL_SUMMARY:   rdata_o[0] = summary_i;
      default:       rdata_o = '0;
    endcase
  end

  a_r10_arm_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_RISE_ARM) |=> (rise_arm_q == $past(wdata_i)));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              ext_irq_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              port_pend_o,
  output logic              wake_o
);
  logic [NPINS-1:0] rise_arm, fall_arm;
  logic [NPINS-1:0] rise_tog, fall_tog, rise_sync, fall_sync;
  logic [NPINS-1:0] rise_pend, fall_pend;
  logic             clr_we, unseen;

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pin
      gpio_edge_cap #(.FALLING(1'b0)) u_rise (
        .pin_i(pin_i[g]), .rst_ni(rst_ni), .arm_i(rise_arm[g]), .tog_o(rise_tog[g]));
      gpio_edge_cap #(.FALLING(1'b1)) u_fall (
        .pin_i(pin_i[g]), .rst_ni(rst_ni), .arm_i(fall_arm[g]), .tog_o(fall_tog[g]));
    end
  endgenerate

  gpio_edge_sync #(.W(NPINS)) u_sync_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rise_tog), .q_o(rise_sync));
  gpio_edge_sync #(.W(NPINS)) u_sync_fall (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fall_tog), .q_o(fall_sync));

  gpio_edge_pend #(.NPINS(NPINS)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rise_raw_i(rise_tog), .fall_raw_i(fall_tog),
    .rise_sync_i(rise_sync), .fall_sync_i(fall_sync),
    .clr_we_i(clr_we), .clr_mask_i(bus_wdata_i),
    .rise_pend_o(rise_pend), .fall_pend_o(fall_pend),
    .unseen_o(unseen));

  gpio_edge_regs #(.NPINS(NPINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rise_pend_i(rise_pend), .fall_pend_i(fall_pend), .summary_i(port_pend_o),
    .rise_arm_o(rise_arm), .fall_arm_o(fall_arm),
    .clr_we_o(clr_we), .rdata_o(bus_rdata_o));

  assign port_pend_o = |(rise_pend | fall_pend);
  assign irq_o       = port_pend_o | ext_irq_i;
  assign wake_o      = port_pend_o | unseen;

  a_r8_wake_covers_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_pend || |fall_pend) |-> wake_o);
  a_r9_ext_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_irq_i |-> irq_o);
  a_r9_pend_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_pend_o |-> irq_o);
endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          clk_run = 1'b1;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic          ext_irq = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq, ppend, wake;

  int errors = 0;
  int checks = 0;
  int popped = 0;
  int pushed = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]   a;
    logic [N-1:0] v;
    string        tag;
  } exp_t;
  exp_t sb_q[$];

  gpio_edge_irq #(.NPINS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .ext_irq_i(ext_irq),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .port_pend_o(ppend), .wake_o(wake));

  initial forever #2 clk = clk_run ? ~clk : clk;

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: push an expected register value, wait until the monitor has compared it.
  task automatic expect_reg(input logic [2:0] a, input logic [N-1:0] v, input string tag);
    exp_t e;
    e.a = a; e.v = v; e.tag = tag;
    sb_q.push_back(e);
    pushed++;
    wait (popped == pushed);
  endtask

  // Monitor: pops expectations and compares the read data.
  initial forever begin
    exp_t e;
    wait (sb_q.size() > 0);
    e = sb_q.pop_front();
    addr = e.a;
    #1;
    chk(rdata === e.v, e.tag, rdata, e.v);
    popped++;
  end

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic pin(input int idx, input logic v);
    @(negedge clk);
    pins[idx] = v;
    settle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) expect_reg(3'(a), '0, "R1 reset register");
    chk(irq === 1'b0 && ppend === 1'b0 && wake === 1'b0, "R1 reset outputs",
        {irq, ppend, wake}, '0);

    // R10 arm registers read back
    wr(3'd0, 32'h0000_002D);
    wr(3'd1, 32'h0000_0006);
    expect_reg(3'd0, 32'h2D, "R10 rise arm readback");
    expect_reg(3'd1, 32'h06, "R10 fall arm readback");

    // R2 rising on armed pin 0
    pin(0, 1'b1);
    expect_reg(3'd2, 32'h1, "R2 rise pending pin0");
    expect_reg(3'd3, 32'h0, "R2 fall untouched");
    chk(irq === 1'b1 && wake === 1'b1, "R9 irq and R8 wake with pending", {irq, wake}, 2'b11);
    expect_reg(3'd5, 32'h1, "R9 summary bit");

    // R2 rise on pin 1, which is armed for falling only
    pin(1, 1'b1);
    expect_reg(3'd2, 32'h1, "R2 unarmed rise ignored");
    // R3 falling on pin 1
    pin(1, 1'b0);
    expect_reg(3'd3, 32'h2, "R3 fall pending pin1");
    // R3 both directions on pin 2
    pin(2, 1'b1);
    pin(2, 1'b0);
    expect_reg(3'd2, 32'h5, "R3 both: rise pin2");
    expect_reg(3'd3, 32'h6, "R3 both: fall pin2");

    // R4 clear with zero does nothing, clear of pin 2 clears both views
    wr(3'd4, 32'h0);
    expect_reg(3'd2, 32'h5, "R4 zero clear no effect");
    wr(3'd4, 32'h4);
    expect_reg(3'd2, 32'h1, "R4 clear rise pin2");
    expect_reg(3'd3, 32'h2, "R4 clear fall pin2");
    expect_reg(3'd4, 32'h0, "R4 clear reads zero");
    wr(3'd4, 32'h3);
    expect_reg(3'd2, 32'h0, "R4 clear rise all");
    expect_reg(3'd3, 32'h0, "R4 clear fall all");

    // R6 pin 0 still high: no new event
    settle();
    expect_reg(3'd2, 32'h0, "R6 level held, no event");
    chk(ppend === 1'b0 && irq === 1'b0 && wake === 1'b0, "R6 outputs low",
        {irq, ppend, wake}, '0);

    // R9 external line alone
    @(negedge clk); ext_irq = 1'b1;
    #1 chk(irq === 1'b1 && ppend === 1'b0, "R9 ext irq passes", {irq, ppend}, 2'b10);
    @(negedge clk); ext_irq = 1'b0;

    // R7 disarm keeps pending, blocks new events
    pin(0, 1'b0);
    pin(0, 1'b1);
    expect_reg(3'd2, 32'h1, "R7 pending before disarm");
    wr(3'd0, 32'h0000_002C);
    settle();
    expect_reg(3'd2, 32'h1, "R7 pending kept after disarm");
    wr(3'd4, 32'h1);
    pin(0, 1'b0);
    pin(0, 1'b1);
    expect_reg(3'd2, 32'h0, "R7 no event when disarmed");
    chk(wake === 1'b0, "R7 wake low when disarmed", wake, 0);

    // R5 edge collides with clear on pin 3
    pin(3, 1'b1);
    pin(3, 1'b0);
    expect_reg(3'd2, 32'h8, "R5 pin3 pending before collision");
    @(negedge clk); pins[3] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd4; wdata = 32'h8;
    @(negedge clk); we = 1'b0; wdata = '0;
    settle();
    expect_reg(3'd2, 32'h8, "R5 new edge wins over clear");
    wr(3'd4, 32'h8);
    settle();
    expect_reg(3'd2, 32'h0, "R4 clear without edge");

    // R8 capture with clock stopped
    @(negedge clk); clk_run = 1'b0;
    #10 pins[5] = 1'b1;
    #10 chk(wake === 1'b1, "R8 wake with clock stopped", wake, 1);
    chk(ppend === 1'b0, "R8 no pending before clock", ppend, 0);
    #10 clk_run = 1'b1;
    settle();
    expect_reg(3'd2, 32'h20, "R8 event recorded after clock resumes");
    chk(wake === 1'b1, "R8 wake held while pending", wake, 1);
    wr(3'd4, 32'h20);
    settle();
    chk(wake === 1'b0, "R8 wake released after clear", wake, 0);

    finish_run();
  end
endmodule